// File: doc/BRIEF.md
# Counter Match Wait Unit

This execution unit holds a processor core until a shared free-running counter reaches a target value. The target comes in the destination operand and an increment in the source operand. When the counter reaches the target, the unit releases the core and writes the target plus the increment back to the destination. A program can therefore re-arm a periodic wait with one instruction per period. The counter comes from outside the unit and wraps modulo 2^CNT_W.

The unit does not start comparing at once. The first comparison falls in the fourth cycle of the instruction, counted from the cycle in which the start strobe is high (cycle 0). A match is registered, and the release follows two cycles after the matching counter value. So the shortest wait is six cycles.

A target that the counter passes during cycles 0 to 2 is not seen. The unit then waits until the counter wraps round to that value again. If the condition bit is low, the instruction is a four-cycle no-op and writes nothing. The core stalls rather than flushes, so the result write lands in the final cycle of the instruction.

Top module: `cntwait_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `stall`, `resume` and `wr_en` are all low.
- R2: With `cond_en` high, `cnt` in cycle 0 equal to c0 and the target equal to c0+3, `resume` is high in cycle 5. This is the six-cycle minimum.
- R3: With `cond_en` high and the target equal to c0+d for d >= 3, `resume` is high in cycle d+2. Each extra cycle of offset delays completion by exactly one clock. Measured against a counter sample taken six cycles before cycle 0, an offset of 9 is caught.
- R4: A target equal to c0+d with d in 0..2 is missed, and `resume` rises in cycle d+2^CNT_W+2. Measured against a sample taken six cycles before cycle 0, an offset of 8 is missed.
- R5: `wr_en` is high only in the `resume` cycle of an enabled instruction. `wr_data` then equals target plus increment, modulo 2^CNT_W.
- R6: With `cond_en` low, `resume` is high in cycle 3, `wr_en` stays low, and the counter value has no effect.
- R7: `stall` is high from cycle 1 up to the cycle before `resume`, and low in cycle 0 and in the `resume` cycle. `stall` and `resume` are never high together.
- R8: A `start` pulse while `stall` is high is ignored. Completion time and `wr_data` follow the instruction already running.
- R9: A `start` in the `resume` cycle is accepted as cycle 0 of the next instruction.
- R10: The operands are captured in cycle 0. Later changes on `dst_val` or `src_val` alter neither the match nor `wr_data`.
- R11: The match is a full equality test on the wrapping counter, so a target of zero is caught as the counter wraps. The sum in R5 wraps in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction begins; this cycle is cycle 0 |
| cond_en | input | 1 | Condition passed; low makes the instruction a no-op |
| dst_val | input | CNT_W | Target value (destination operand) |
| src_val | input | CNT_W | Increment (source operand) |
| cnt | input | CNT_W | Shared free-running counter |
| stall | output | 1 | Core held |
| resume | output | 1 | Final cycle of the instruction; core released |
| wr_en | output | 1 | Destination write enable |
| wr_data | output | CNT_W | Target plus increment |

## Verification
Two events can fall in one cycle: the completion of one instruction (`resume` with its write) and the acceptance of the next one's `start`. The bench provokes this by raising `start` in the cycle where the first wait is predicted to end. It then checks two things. The first write carries the first operands. The second instruction's completion is counted from that shared cycle. A second overlap is a match in the same cycle as the counter wrap, provoked with a target of zero. A cycle-accurate model in the bench judges every output on every clock.

// File: rtl/cntwait_pkg.sv
package cntwait_pkg;

    // Cycle budget of one wait instruction, counted from the start cycle.
    localparam int MIN_CYC    = 6;
    localparam int NOP_CYC    = 4;
    localparam int RESUME_LAT = 2;
    // First cycle index in which the counter is compared.
    localparam int CMP_STAGE  = MIN_CYC - 1 - RESUME_LAT;
    localparam int PH_W       = $clog2(NOP_CYC + MIN_CYC);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SKIP,
        SQ_SETUP,
        SQ_HUNT,
        SQ_ARM,
        SQ_FIN
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic hunting;
        logic last;
        logic writes;
        logic accept;
    } seq_view_t;

endpackage

// File: rtl/cntwait_seq.sv
module cntwait_seq
    import cntwait_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cond_en,
    input  logic      hit,
    output seq_view_t view
);

    seq_state_e           st;
    logic [PH_W-1:0]      ph;
    logic                 last_c;
    logic                 accept_c;

    always_comb begin
        last_c   = (st == SQ_FIN) ||
                   ((st == SQ_SKIP) && (ph == PH_W'(NOP_CYC - 1)));
        accept_c = start && ((st == SQ_IDLE) || last_c);

        view.busy    = (st != SQ_IDLE);
        view.hunting = (st == SQ_HUNT);
        view.last    = last_c;
        view.writes  = (st == SQ_FIN);
        view.accept  = accept_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SQ_IDLE;
            ph <= '0;
        end else if (accept_c) begin
            st <= cond_en ? SQ_SETUP : SQ_SKIP;
            ph <= PH_W'(1);
        end else begin
            case (st)
                SQ_SKIP: begin
                    if (last_c) st <= SQ_IDLE;
                    else        ph <= ph + 1'b1;
                end
                SQ_SETUP: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_W'(CMP_STAGE - 1)) st <= SQ_HUNT;
                end
                SQ_HUNT: begin
                    if (hit) st <= SQ_ARM;
                end
                SQ_ARM:  st <= SQ_FIN;
                SQ_FIN:  st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cntwait_cmp.sv
module cntwait_cmp #(
    parameter int CNT_W  = 32,
    parameter int LANE_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] target,
    input  logic             hunting,
    output logic             hit
);

    localparam int LANES = (CNT_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] cnt_p;
    logic [PAD_W-1:0] tgt_p;
    logic [LANES-1:0] lane_eq;

    assign cnt_p = PAD_W'(cnt);
    assign tgt_p = PAD_W'(target);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (cnt_p[g*LANE_W +: LANE_W] == tgt_p[g*LANE_W +: LANE_W]);
    end

    assign hit = hunting && (&lane_eq);

endmodule

// File: rtl/cntwait_wb.sv
module cntwait_wb #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CNT_W-1:0] dst_val,
    input  logic [CNT_W-1:0] src_val,
    output logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] result
);

    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            inc_q <= '0;
        end else if (accept) begin
            tgt_q <= dst_val;
            inc_q <= src_val;
        end
    end

    assign target = tgt_q;
    assign result = tgt_q + inc_q;

endmodule

// File: rtl/cntwait_unit.sv
module cntwait_unit
    import cntwait_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cond_en,
    input  logic [CNT_W-1:0] dst_val,
    input  logic [CNT_W-1:0] src_val,
    input  logic [CNT_W-1:0] cnt,
    output logic             stall,
    output logic             resume,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_data
);

    seq_view_t        view;
    logic             hit;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] result;

    cntwait_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cond_en (cond_en),
        .hit     (hit),
        .view    (view)
    );

    cntwait_cmp #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_cmp (
        .cnt     (cnt),
        .target  (target),
        .hunting (view.hunting),
        .hit     (hit)
    );

    cntwait_wb #(.CNT_W(CNT_W)) u_wb (
        .clk     (clk),
        .rst     (rst),
        .accept  (view.accept),
        .dst_val (dst_val),
        .src_val (src_val),
        .target  (target),
        .result  (result)
    );

    assign stall   = view.busy && !view.last;
    assign resume  = view.last;
    assign wr_en   = view.writes;
    assign wr_data = result;

endmodule

// File: rtl/cntwait_unit_chk.sv
module cntwait_unit_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stall,
    input logic             resume,
    input logic             wr_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] dst_val,
    input logic [CNT_W-1:0] src_val,
    input logic [CNT_W-1:0] wr_data
);

    logic             acc;
    logic [CNT_W-1:0] sh_tgt;
    logic [CNT_W-1:0] sh_inc;
    logic [3:0]       age;

    assign acc = start && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_tgt <= '0;
            sh_inc <= '0;
            age    <= '0;
        end else if (acc) begin
            sh_tgt <= dst_val;
            sh_inc <= src_val;
            age    <= 4'd1;
        end else if (age != 4'd15) begin
            age <= age + 4'd1;
        end
    end

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(stall && resume));

    p_stall_after_start_r7: assert property (@(posedge clk) disable iff (rst)
        acc |=> stall);

    p_wr_in_resume_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> resume);

    p_sum_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data == CNT_W'(sh_tgt + sh_inc)));

    p_match_lat_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(cnt, 2) == sh_tgt));

    p_min_len_r2: assert property (@(posedge clk) disable iff (rst)
        (resume && wr_en) |-> (age >= 4'd5));

    p_nop_len_r6: assert property (@(posedge clk) disable iff (rst)
        (resume && !wr_en) |-> (age == 4'd3));

endmodule

bind cntwait_unit cntwait_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stall   (stall),
    .resume  (resume),
    .wr_en   (wr_en),
    .cnt     (cnt),
    .dst_val (dst_val),
    .src_val (src_val),
    .wr_data (wr_data)
);

// File: tb/cntwait_unit_test.sv
module cntwait_unit_test;

    localparam int W    = 8;
    localparam int WRAP = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cond_en = 1'b0;
    logic [W-1:0] dst_val = '0;
    logic [W-1:0] src_val = '0;
    logic [W-1:0] cnt = '0;
    logic         stall, resume, wr_en;
    logic [W-1:0] wr_data;

    int  vectors = 0;
    int  misses  = 0;
    bit  reported = 0;

    always #4 clk = ~clk;

    always @(posedge clk) cnt <= rst ? '0 : cnt + 1'b1;

    cntwait_unit #(.CNT_W(W), .LANE_W(4)) uut (
        .clk(clk), .rst(rst), .start(start), .cond_en(cond_en),
        .dst_val(dst_val), .src_val(src_val), .cnt(cnt),
        .stall(stall), .resume(resume), .wr_en(wr_en), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    // Reference model: cycles left until the final cycle, -1 when idle.
    int           left = -1;
    bit           m_wr = 0;
    logic [W-1:0] m_data = '0;

    always @(negedge clk) begin
        if (rst) begin
            left = -1;
        end else begin
            chk("R7 stall per cycle", stall, left > 0);
            chk("R3 resume per cycle", resume, left == 0);
            chk("R5 wr_en per cycle", wr_en, (left == 0) && m_wr);
            if (left == 0 && m_wr) chk("R5 wr_data per cycle", wr_data, m_data);
            if (start && left <= 0) begin
                logic [W-1:0] dd;
                int d;
                dd = dst_val - cnt;
                d  = int'(dd);
                if (d < 3) d += WRAP;
                left   = cond_en ? d + 1 : 2;
                m_wr   = cond_en;
                m_data = dst_val + src_val;
            end else if (left >= 0) begin
                left--;
            end
        end
    end

    // Waits for resume, starting in cycle index k0; returns final index.
    task automatic wait_done(input int k0, output int k, output bit w,
                             output logic [W-1:0] data);
        k = k0;
        forever begin
            @(negedge clk);
            if (resume) break;
            k++;
        end
        w    = wr_en;
        data = wr_data;
    endtask

    // One instruction; tgt_zero forces a target of zero.
    task automatic op(input string tag, input bit en, input int d,
                      input bit tgt_zero, input logic [W-1:0] inc);
        logic [W-1:0] tgt, dd;
        int k, ek;
        bit w;
        logic [W-1:0] data;
        @(posedge clk); #1;
        tgt = tgt_zero ? '0 : cnt + W'(d);
        dd  = tgt - cnt;
        start = 1'b1; cond_en = en; dst_val = tgt; src_val = inc;
        @(posedge clk); #1;
        start = 1'b0; dst_val = ~tgt; src_val = ~inc;   // R10 perturbation
        wait_done(1, k, w, data);
        if (!en)           ek = 3;
        else if (dd < 3)   ek = int'(dd) + WRAP + 2;
        else               ek = int'(dd) + 2;
        chk({tag, " final cycle"}, k, ek);
        chk({tag, " write flag"}, w, en);
        if (en) chk({tag, " R10 data from captured operands"}, data, W'(tgt + inc));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int k;
        bit w;
        logic [W-1:0] data, t1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 stall in reset", stall, 0);
        chk("R1 resume in reset", resume, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 stall after reset", stall, 0);
        chk("R1 resume after reset", resume, 0);
        chk("R1 wr_en after reset", wr_en, 0);

        op("R2 minimum", 1, 3, 0, 8'd5);
        op("R3 offset 4", 1, 4, 0, 8'd1);
        op("R3 offset 7", 1, 7, 0, 8'd100);
        op("R3 offset 9 from early sample", 1, 9 - 6, 0, 8'd2);
        op("R3 offset 20", 1, 20, 0, 8'd3);
        op("R4 offset 8 from early sample missed", 1, 8 - 6, 0, 8'd7);
        op("R4 offset 0 missed", 1, 0, 0, 8'd9);
        op("R6 disabled", 0, 3, 0, 8'd4);
        op("R6 disabled far target", 0, 50, 0, 8'd4);
        op("R11 sum wraps", 1, 6, 0, 8'hF0);

        // R11: target zero, counter wraps during the wait.
        @(posedge clk); #1;
        while (cnt < 8'd200) begin @(posedge clk); #1; end
        op("R11 target zero", 1, 0, 1, 8'd3);

        // R8: start during stall is ignored.
        @(posedge clk); #1;
        t1 = cnt + 8'd30;
        start = 1'b1; cond_en = 1'b1; dst_val = t1; src_val = 8'd11;
        @(posedge clk); #1 start = 1'b0;
        repeat (4) @(posedge clk);
        #1 start = 1'b1; dst_val = cnt + 8'd3; src_val = 8'd99;
        @(posedge clk); #1 start = 1'b0;
        wait_done(6, k, w, data);
        chk("R8 final cycle unchanged", k, 32);
        chk("R8 data unchanged", data, W'(t1 + 8'd11));

        // R9: next start in the resume cycle.
        @(posedge clk); #1;
        t1 = cnt + 8'd5;
        start = 1'b1; cond_en = 1'b1; dst_val = t1; src_val = 8'd1;
        @(posedge clk); #1 start = 1'b0;
        repeat (6) @(posedge clk);
        #1 start = 1'b1; dst_val = cnt + 8'd4; src_val = 8'd2; t1 = cnt + 8'd4;
        @(negedge clk);
        chk("R9 first resume", resume, 1);
        chk("R9 first write", wr_en, 1);
        @(posedge clk); #1 start = 1'b0;
        wait_done(1, k, w, data);
        chk("R9 second final cycle", k, 6);
        chk("R9 second data", data, W'(t1 + 8'd2));

        repeat (3) @(posedge clk);
        summary();
    end

endmodule